// File: doc/BRIEF.md
# Serial Divider Programming Interface

This block is the programming front end that sets the divide ratios of a frequency synthesizer. A host drives three wires: a data bit, a shift clock and a load enable. Each rising edge of the shift clock moves one data bit into a 32-bit frame register, most significant bit first. After a full frame has been shifted in, the host raises the load enable. The swallow (A) and main (N) divide values then pass into their holding registers. The reference divide value passes into its holding register only when the last bit shifted, the control bit, is 1.

The three serial wires are asynchronous to the block clock. Each wire passes through a synchronizer of the same depth, so the three stay aligned. Shift-clock edges are detected in the block clock domain. The holding registers act as transparent latches. While the enable is high they follow the frame register on every block clock. While it is low they keep their value, even if more bits are shifted in. The latched values drive the downstream reference, A and N counters.

Top module: `divprog_if`

## Requirements
- R1: While rst_n is low, ref_div, n_div and a_div are all zero.
- R2: Each rising edge of ser_clk shifts exactly one ser_data bit into the frame register, most significant bit first. A ser_clk level held high does not cause more shifts.
- R3: Frame layout, from the first bit shifted to the last: the 14-bit reference value (MSB first), the 10-bit N value, the 7-bit A value, then one control bit. After 32 shifts the control bit sits in bit 0, A in bits 7:1, N in bits 17:8 and the reference value in bits 31:18.
- R4: While ser_load is high and the control bit is 1, ref_div takes the reference field of the frame register.
- R5: While ser_load is high and the control bit is 0, ref_div keeps its previous value.
- R6: While ser_load is high, n_div and a_div take the N and A fields, whatever the control bit holds.
- R7: While ser_load is low, ref_div, n_div and a_div do not change, even while bits are being shifted in.
- R8: While ser_load stays high, further shifts flow through to the outputs. The control-bit rule still governs ref_div.
- R9: A ser_load level sampled at block clock edge k first affects the outputs at edge k+SYNC_STAGES. With the default of 2, the outputs are unchanged after edges k and k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial programming data |
| ser_clk | input | 1 | Serial shift clock; shifts on its rising edge |
| ser_load | input | 1 | Latch enable; held low at rest, pulsed high to load |
| ref_div | output | REF_W | Latched reference divide value |
| n_div | output | N_W | Latched main (N) divide value |
| a_div | output | A_W | Latched swallow (A) divide value |

## Verification
The bench targets four corner cases:
- A frame whose control bit is 0, loaded after a frame whose control bit is 1. A design that ignored the control bit would overwrite the reference value; a design that gated all latches on it would fail to update N and A.
- A new frame shifted in while the enable is low. A design whose latches were not level-gated would leak the new bits to the outputs early.
- Enable held high across an extra shift. This shows transparency and the re-steered control bit.
- The all-ones and all-zeros frames, and the exact edge at which a rising enable first reaches the outputs. A reordered frame or a synchronizer of the wrong depth shows up here.

A behavioural model compares every output on every clock. It catches double shifts on a held shift clock and off-by-one field boundaries.

// File: rtl/divprog_pkg.sv
package divprog_pkg;

    localparam int unsigned DEF_REF_W  = 14;
    localparam int unsigned DEF_N_W    = 10;
    localparam int unsigned DEF_A_W    = 7;
    localparam int unsigned DEF_SYNC   = 2;

    // The three serial wires, carried together through the synchronizer
    typedef struct packed {
        logic data;
        logic sck;
        logic load;
    } ser_pins_t;

endpackage

// File: rtl/divprog_sync.sv
module divprog_sync
    import divprog_pkg::*;
#(
    parameter int unsigned STAGES = DEF_SYNC
) (
    input  logic      clk,
    input  logic      rst_n,
    input  ser_pins_t pins_i,
    output ser_pins_t pins_o,
    output logic      sck_rise_o
);

    typedef struct packed {
        ser_pins_t [STAGES-1:0] pipe;
        logic                   sck_prev;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = pins_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.sck_prev = s_q.pipe[STAGES-1].sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pins_o     = s_q.pipe[STAGES-1];
    assign sck_rise_o = s_q.pipe[STAGES-1].sck & ~s_q.sck_prev;

endmodule

// File: rtl/divprog_shifter.sv
module divprog_shifter #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] frame_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (shift_i) begin
            s_d.sr = {s_q.sr[WIDTH-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_o = s_q.sr;

endmodule

// File: rtl/divprog_latch.sv
module divprog_latch #(
    parameter int unsigned REF_W = 14,
    parameter int unsigned N_W   = 10,
    parameter int unsigned A_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [REF_W+N_W+A_W:0]   frame_i,
    output logic [REF_W-1:0]         ref_o,
    output logic [N_W-1:0]           n_o,
    output logic [A_W-1:0]           a_o
);

    localparam int unsigned CTRL_POS = 0;
    localparam int unsigned A_LSB    = 1;
    localparam int unsigned N_LSB    = A_LSB + A_W;
    localparam int unsigned REF_LSB  = N_LSB + N_W;

    typedef struct packed {
        logic [REF_W-1:0] ref_v;
        logic [N_W-1:0]   n_v;
        logic [A_W-1:0]   a_v;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.n_v = frame_i[N_LSB +: N_W];
            s_d.a_v = frame_i[A_LSB +: A_W];
            if (frame_i[CTRL_POS]) begin
                s_d.ref_v = frame_i[REF_LSB +: REF_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ref_o = s_q.ref_v;
    assign n_o   = s_q.n_v;
    assign a_o   = s_q.a_v;

endmodule

// File: rtl/divprog_if.sv
module divprog_if
    import divprog_pkg::*;
#(
    parameter int unsigned REF_W       = DEF_REF_W,
    parameter int unsigned N_W         = DEF_N_W,
    parameter int unsigned A_W         = DEF_A_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             ser_clk,
    input  logic             ser_load,
    output logic [REF_W-1:0] ref_div,
    output logic [N_W-1:0]   n_div,
    output logic [A_W-1:0]   a_div
);

    localparam int unsigned FRAME_W = REF_W + N_W + A_W + 1;

    ser_pins_t            pins_raw;
    ser_pins_t            pins_s;
    logic                 sck_rise;
    logic                 data_s;
    logic                 load_s;
    logic [FRAME_W-1:0]   frame;

    assign pins_raw = {ser_data, ser_clk, ser_load};
    assign data_s   = pins_s.data;
    assign load_s   = pins_s.load;

    divprog_sync #(
        .STAGES     (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins_raw),
        .pins_o     (pins_s),
        .sck_rise_o (sck_rise)
    );

    divprog_shifter #(
        .WIDTH      (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (sck_rise),
        .bit_i      (data_s),
        .frame_o    (frame)
    );

    divprog_latch #(
        .REF_W      (REF_W),
        .N_W        (N_W),
        .A_W        (A_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_s),
        .frame_i    (frame),
        .ref_o      (ref_div),
        .n_o        (n_div),
        .a_o        (a_div)
    );

endmodule

// File: rtl/divprog_checker.sv
module divprog_checker #(
    parameter int unsigned REF_W = 14,
    parameter int unsigned N_W   = 10,
    parameter int unsigned A_W   = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   load_s,
    input logic                   sck_rise,
    input logic                   data_s,
    input logic [REF_W+N_W+A_W:0] frame,
    input logic [REF_W-1:0]       ref_div,
    input logic [N_W-1:0]         n_div,
    input logic [A_W-1:0]         a_div
);

    localparam int unsigned FW      = REF_W + N_W + A_W + 1;
    localparam int unsigned A_LSB   = 1;
    localparam int unsigned N_LSB   = A_LSB + A_W;
    localparam int unsigned REF_LSB = N_LSB + N_W;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (ref_div == '0 && n_div == '0 && a_div == '0)
                else $error("outputs not cleared in reset");
        end
    end

    p_shift_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise |=> (frame == {$past(frame[FW-2:0]), $past(data_s)}));

    p_no_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_rise |=> $stable(frame));

    p_ref_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && frame[0]) |=> (ref_div == $past(frame[REF_LSB +: REF_W])));

    p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && !frame[0]) |=> $stable(ref_div));

    p_an_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_s |=> (n_div == $past(frame[N_LSB +: N_W]) && a_div == $past(frame[A_LSB +: A_W])));

    p_hold_when_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_s |=> ($stable(ref_div) && $stable(n_div) && $stable(a_div)));

endmodule

bind divprog_if divprog_checker #(
    .REF_W    (REF_W),
    .N_W      (N_W),
    .A_W      (A_W)
) u_divprog_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_s   (load_s),
    .sck_rise (sck_rise),
    .data_s   (data_s),
    .frame    (frame),
    .ref_div  (ref_div),
    .n_div    (n_div),
    .a_div    (a_div)
);

// File: tb/test_divprog_if.sv
module test_divprog_if;

    localparam int SYNC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_load = 1'b0;
    logic [13:0] ref_div;
    logic [9:0]  n_div;
    logic [6:0]  a_div;

    int total = 0;
    int bad = 0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    divprog_if i_divprog_if (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_data (ser_data),
        .ser_clk  (ser_clk),
        .ser_load (ser_load),
        .ref_div  (ref_div),
        .n_div    (n_div),
        .a_div    (a_div)
    );

    // Behavioural reference: input history queue plus 32-bit frame image
    logic [2:0]  hist[$];
    logic [2:0]  cur, prv;
    logic [31:0] m_sr;
    logic [13:0] m_ref;
    logic [9:0]  m_n;
    logic [6:0]  m_a;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {};
            for (int i = 0; i < SYNC + 2; i++) hist.push_back(3'b000);
            m_sr = '0; m_ref = '0; m_n = '0; m_a = '0;
        end else begin
            hist.push_front({ser_data, ser_clk, ser_load});
            void'(hist.pop_back());
            cur = hist[SYNC];
            prv = hist[SYNC+1];
            if (cur[0]) begin
                m_n = m_sr[17:8];
                m_a = m_sr[7:1];
                if (m_sr[0]) m_ref = m_sr[31:18];
            end
            if (cur[1] && !prv[1]) m_sr = {m_sr[30:0], cur[2]};
        end
    end

    task automatic chk(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R4 R5 model ref_div", int'(ref_div), int'(m_ref));
            chk("R6 model n_div", int'(n_div), int'(m_n));
            chk("R6 model a_div", int'(a_div), int'(m_a));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        ser_data = b;
        tick(1);
        ser_clk = 1'b1;
        tick(2);
        ser_clk = 1'b0;
        tick(1);
    endtask

    task automatic send_frame(logic [13:0] r, logic [9:0] n, logic [6:0] a, logic c);
        logic [31:0] f;
        f = {r, n, a, c};
        for (int i = 31; i >= 0; i--) shift_bit(f[i]);
        tick(4);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1;
        tick(4);
        ser_load = 1'b0;
        tick(4);
    endtask

    task automatic expect_out(string tag, logic [13:0] r, logic [9:0] n, logic [6:0] a);
        chk({tag, " ref_div"}, int'(ref_div), int'(r));
        chk({tag, " n_div"}, int'(n_div), int'(n));
        chk({tag, " a_div"}, int'(a_div), int'(a));
    endtask

    initial begin
        logic [31:0] nsr;
        tick(4);
        expect_out("R1 reset", 14'h0, 10'h0, 7'h0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick(2);

        // Frame with control 1, shifted while load low
        send_frame(14'h2A5C, 10'h3A1, 7'h55, 1'b1);
        expect_out("R7 shift while idle", 14'h0, 10'h0, 7'h0);
        pulse_load();
        expect_out("R2 R3 R4 R6 load ctrl1", 14'h2A5C, 10'h3A1, 7'h55);

        // Control 0: reference held, A/N updated
        send_frame(14'h1111, 10'h0F0, 7'h0A, 1'b0);
        pulse_load();
        chk("R5 ref held ctrl0", int'(ref_div), 32'h2A5C);
        chk("R6 n loads ctrl0", int'(n_div), 32'h0F0);
        chk("R6 a loads ctrl0", int'(a_div), 32'h0A);

        // All-ones boundary
        send_frame(14'h3FFF, 10'h3FF, 7'h7F, 1'b1);
        pulse_load();
        expect_out("R3 all ones", 14'h3FFF, 10'h3FF, 7'h7F);

        // Latency of load, then transparency
        send_frame(14'h0001, 10'h200, 7'h40, 1'b1);
        expect_out("R7 idle after shift", 14'h3FFF, 10'h3FF, 7'h7F);
        ser_load = 1'b1;
        tick(1);
        expect_out("R9 edge k", 14'h3FFF, 10'h3FF, 7'h7F);
        tick(1);
        expect_out("R9 edge k+1", 14'h3FFF, 10'h3FF, 7'h7F);
        tick(1);
        expect_out("R9 edge k+2", 14'h0001, 10'h200, 7'h40);
        shift_bit(1'b1);
        tick(4);
        nsr = {14'h0001, 10'h200, 7'h40, 1'b1};
        nsr = {nsr[30:0], 1'b1};
        expect_out("R8 transparent shift", nsr[31:18], nsr[17:8], nsr[7:1]);
        ser_load = 1'b0;
        tick(4);

        // All-zeros boundary with control 1
        send_frame(14'h0, 10'h0, 7'h0, 1'b1);
        pulse_load();
        expect_out("R3 all zeros", 14'h0, 10'h0, 7'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule